// File: doc/BRIEF.md
# Instruction Decoder with Register Reference-Count Scoreboard

This block sits in the decode stage of a small in-order pipeline. It splits a 16-bit instruction word into its opcode, destination index, two source indices and an 8-bit immediate. From the opcode it chooses which register indices must be read. It drives the register-file read addresses and returns the operand values that come back. It also checks each index it reads against a per-register busy counter.

If any register the instruction reads still has a write in flight, the block raises a read-after-write stall. Otherwise it issues the instruction. An issued instruction that produces a register result adds one to that register's counter. The later pipeline signals each completed register write through a release strobe, and that strobe lowers the counter by one. Counters are reference counts, so several writes to the same register can be outstanding at once. A register counts as free only when all of them have retired. Execution, memory access and branch resolution are left to the stages downstream.

Top module: `sbd_decoder`

## Requirements
- R1: `opcode_o` carries instruction bits 15:12, `rd_o` bits 11:8, `rs1_o` bits 7:4 and `rs2_o` bits 3:0, combinationally.
- R2: Opcode values are 0 ADD, 1 SUB, 2 MUL, 3 INC, 4 AND, 5 OR, 6 XOR, 7 NOT, 8 SLLI, 9 SRLI, 10 LI, 11 LD, 12 ST, 13 JMP, 14 BEQZ, 15 HLT. Opcodes 0 to 11 write `rd`.
- R3: `imm_o` is bits 7:0, except for JMP (13), where it is bits 11:4.
- R4: Read port A reads rs1 for opcodes 0-2, 4-9, 11 and 12, and reads rd for INC and BEQZ. Read port B reads rs2 for opcodes 0-2 and 4-6, and reads rd for ST. `op_a_o`/`op_b_o` return the port data when the port is used and zero otherwise. LI, JMP and HLT read nothing.
- R5: With `instr_valid_i` high, `stall_o` is high exactly when a register read under R4 has a nonzero busy count, or when R7 applies. Otherwise `issue_o` is high. Both are low while `instr_valid_i` is low.
- R6: An issued instruction with opcode 0 to 11 adds one to the busy count of `rd` at the next clock edge. ST, JMP, BEQZ and HLT, and stalled instructions, change no count.
- R7: An instruction with opcode 0 to 11 whose `rd` count is at its maximum (2^CNT_W-1) stalls.
- R8: `wb_en_i` lowers the count of `wb_idx_i` by one. When an issue and a release hit the same register in the same cycle, its count is unchanged.
- R9: A release on a register whose count is zero is ignored. The count stays zero.
- R10: `jump_o` is high for an issued JMP or BEQZ, and `halt_o` for an issued HLT. JMP and HLT never stall.
- R11: Reset clears every count, so no instruction stalls right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 16 | Instruction word |
| instr_valid_i | input | 1 | Instruction present |
| wb_en_i | input | 1 | Register write retired |
| wb_idx_i | input | 4 | Index of retired register |
| rf_ra_o | output | 4 | Register-file read address, port A |
| rf_rb_o | output | 4 | Register-file read address, port B |
| rf_da_i | input | DATA_W | Read data, port A |
| rf_db_i | input | DATA_W | Read data, port B |
| opcode_o | output | 4 | Opcode field |
| rd_o | output | 4 | Destination field |
| rs1_o | output | 4 | First source field |
| rs2_o | output | 4 | Second source field |
| imm_o | output | 8 | Immediate / jump offset |
| op_a_o | output | DATA_W | Operand A |
| op_b_o | output | DATA_W | Operand B |
| issue_o | output | 1 | Instruction issued this cycle |
| stall_o | output | 1 | RAW or count-full stall |
| jump_o | output | 1 | Issued control transfer |
| halt_o | output | 1 | Issued halt |

## Verification
The bench targets a release and an issue that land on the same register in the same cycle. A design that applied only one of the two would leave the count off by one, and a later probe would then stall too early or release too late. It also issues a release on an empty register. A counter that wraps would come back at its maximum and block the next writer to that register. It fills one counter to saturation. A design without the full check would wrap the count to zero and lose in-flight writes. Finally, it probes ST, INC and BEQZ with a busy `rd`. A decoder that checked only the source fields would issue these past a pending write.

// File: rtl/sbd_pkg.sv
package sbd_pkg;

   localparam int FIELD_W = 4;
   localparam int INSTR_W = 4 * FIELD_W;
   localparam int IMM_W   = 2 * FIELD_W;
   localparam int NREG    = 1 << FIELD_W;

   typedef enum logic [FIELD_W-1:0] {
      SBD_ADD  = 4'd0,  SBD_SUB  = 4'd1,  SBD_MUL  = 4'd2,  SBD_INC  = 4'd3,
      SBD_AND  = 4'd4,  SBD_OR   = 4'd5,  SBD_XOR  = 4'd6,  SBD_NOT  = 4'd7,
      SBD_SLLI = 4'd8,  SBD_SRLI = 4'd9,  SBD_LI   = 4'd10, SBD_LD   = 4'd11,
      SBD_ST   = 4'd12, SBD_JMP  = 4'd13, SBD_BEQZ = 4'd14, SBD_HLT  = 4'd15
   } sbd_op_e;

   typedef struct packed {
      logic uses_a;
      logic uses_b;
      logic a_from_rd;
      logic b_from_rd;
      logic writes;
      logic jump;
      logic halt;
   } sbd_cls_t;

   function automatic sbd_cls_t sbd_classify(input sbd_op_e op);
      sbd_cls_t c;
      c = '0;
      unique case (op)
         SBD_ADD, SBD_SUB, SBD_MUL, SBD_AND, SBD_OR, SBD_XOR: begin
            c.uses_a = 1'b1; c.uses_b = 1'b1; c.writes = 1'b1;
         end
         SBD_NOT, SBD_SLLI, SBD_SRLI, SBD_LD: begin
            c.uses_a = 1'b1; c.writes = 1'b1;
         end
         SBD_INC: begin
            c.uses_a = 1'b1; c.a_from_rd = 1'b1; c.writes = 1'b1;
         end
         SBD_LI: c.writes = 1'b1;
         SBD_ST: begin
            c.uses_a = 1'b1; c.uses_b = 1'b1; c.b_from_rd = 1'b1;
         end
         SBD_JMP: c.jump = 1'b1;
         SBD_BEQZ: begin
            c.uses_a = 1'b1; c.a_from_rd = 1'b1; c.jump = 1'b1;
         end
         SBD_HLT: c.halt = 1'b1;
         default: c = '0;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/sbd_field_decode.sv
module sbd_field_decode
   import sbd_pkg::*;
(
   input  logic [INSTR_W-1:0] instr_i,
   output sbd_op_e            op_o,
   output logic [FIELD_W-1:0] rd_o,
   output logic [FIELD_W-1:0] rs1_o,
   output logic [FIELD_W-1:0] rs2_o,
   output logic [IMM_W-1:0]   imm_o,
   output sbd_cls_t           cls_o
);

   sbd_op_e op;

   always_comb begin
      op     = sbd_op_e'(instr_i[INSTR_W-1 -: FIELD_W]);
      rd_o   = instr_i[3*FIELD_W-1 -: FIELD_W];
      rs1_o  = instr_i[2*FIELD_W-1 -: FIELD_W];
      rs2_o  = instr_i[FIELD_W-1:0];
      // The jump offset sits one field higher than the regular immediate.
      imm_o  = (op == SBD_JMP) ? instr_i[3*FIELD_W-1 -: IMM_W]
                               : instr_i[IMM_W-1:0];
      cls_o  = sbd_classify(op);
      op_o   = op;
   end

endmodule

// File: rtl/sbd_busy_cnt.sv
module sbd_busy_cnt #(
   parameter int CNT_W = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc_i,
   input  logic dec_i,
   output logic busy_o,
   output logic full_o
);

   logic [CNT_W-1:0] lvl;

   generate
      if (CNT_W == 1) begin : g_flag
         logic flag_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                  flag_q <= 1'b0;
            else if (inc_i && !flag_q)   flag_q <= 1'b1;
            else if (dec_i && !inc_i)    flag_q <= 1'b0;
         end
         assign lvl = flag_q;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         logic             dec_ok;
         assign dec_ok = dec_i && (cnt_q != '0);
         always_ff @(posedge clk) begin
            if (!rst_n)                  cnt_q <= '0;
            else if (inc_i && !dec_ok)   cnt_q <= cnt_q + 1'b1;
            else if (dec_ok && !inc_i)   cnt_q <= cnt_q - 1'b1;
         end
         assign lvl = cnt_q;
      end
   endgenerate

   assign busy_o = |lvl;
   assign full_o = &lvl;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      full_o |-> !inc_i) else $error("counter incremented while full"); // R7
   AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !dec_i) |=> (lvl == $past(lvl) + 1'b1)) else $error("increment lost"); // R6
   AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && dec_i && busy_o) |=> $stable(lvl)) else $error("inc+dec changed count"); // R8
   AST_ZERO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && !inc_i && !busy_o) |=> !busy_o) else $error("release on empty wrapped"); // R9

endmodule

// File: rtl/sbd_scoreboard.sv
module sbd_scoreboard #(
   parameter int NREG  = 16,
   parameter int CNT_W = 2,
   localparam int IDX_W = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_i,
   input  logic [IDX_W-1:0] alloc_idx_i,
   input  logic             rel_i,
   input  logic [IDX_W-1:0] rel_idx_i,
   input  logic [IDX_W-1:0] qa_idx_i,
   input  logic [IDX_W-1:0] qb_idx_i,
   input  logic [IDX_W-1:0] qd_idx_i,
   output logic             busy_a_o,
   output logic             busy_b_o,
   output logic             full_d_o
);

   logic [NREG-1:0] busy_vec;
   logic [NREG-1:0] full_vec;

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic inc, dec;
      assign inc = alloc_i && (alloc_idx_i == IDX_W'(g));
      assign dec = rel_i   && (rel_idx_i   == IDX_W'(g));
      sbd_busy_cnt #(.CNT_W(CNT_W)) u_cnt (
         .clk    (clk),
         .rst_n  (rst_n),
         .inc_i  (inc),
         .dec_i  (dec),
         .busy_o (busy_vec[g]),
         .full_o (full_vec[g])
      );
   end

   assign busy_a_o = busy_vec[qa_idx_i];
   assign busy_b_o = busy_vec[qb_idx_i];
   assign full_d_o = full_vec[qd_idx_i];

   AST_RESET_IDLE: assert property (@(posedge clk)
      !rst_n |=> (busy_vec == '0)) else $error("reset left a busy count"); // R11

endmodule

// File: rtl/sbd_decoder.sv
module sbd_decoder
   import sbd_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [15:0]        instr_i,
   input  logic               instr_valid_i,
   input  logic               wb_en_i,
   input  logic [3:0]         wb_idx_i,
   output logic [3:0]         rf_ra_o,
   output logic [3:0]         rf_rb_o,
   input  logic [DATA_W-1:0]  rf_da_i,
   input  logic [DATA_W-1:0]  rf_db_i,
   output logic [3:0]         opcode_o,
   output logic [3:0]         rd_o,
   output logic [3:0]         rs1_o,
   output logic [3:0]         rs2_o,
   output logic [7:0]         imm_o,
   output logic [DATA_W-1:0]  op_a_o,
   output logic [DATA_W-1:0]  op_b_o,
   output logic               issue_o,
   output logic               stall_o,
   output logic               jump_o,
   output logic               halt_o
);

   initial begin : elab_chk
      assert (DATA_W >= 1) else $error("DATA_W must be positive");
      assert (CNT_W >= 1 && CNT_W <= 8) else $error("CNT_W out of range 1..8");
      assert (INSTR_W == 16 && IMM_W == 8) else $error("field layout mismatch");
   end

   sbd_op_e            op;
   sbd_cls_t           cls;
   logic [FIELD_W-1:0] rd, rs1, rs2;
   logic [IMM_W-1:0]   imm;
   logic               busy_a, busy_b, full_d;
   logic               hazard;

   sbd_field_decode u_fields (
      .instr_i (instr_i),
      .op_o    (op),
      .rd_o    (rd),
      .rs1_o   (rs1),
      .rs2_o   (rs2),
      .imm_o   (imm),
      .cls_o   (cls)
   );

   assign rf_ra_o = cls.a_from_rd ? rd : rs1;
   assign rf_rb_o = cls.b_from_rd ? rd : rs2;

   sbd_scoreboard #(.NREG(NREG), .CNT_W(CNT_W)) u_sb (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_i     (issue_o && cls.writes),
      .alloc_idx_i (rd),
      .rel_i       (wb_en_i),
      .rel_idx_i   (wb_idx_i),
      .qa_idx_i    (rf_ra_o),
      .qb_idx_i    (rf_rb_o),
      .qd_idx_i    (rd),
      .busy_a_o    (busy_a),
      .busy_b_o    (busy_b),
      .full_d_o    (full_d)
   );

   assign hazard  = (cls.uses_a && busy_a) || (cls.uses_b && busy_b)
                 || (cls.writes && full_d);
   assign stall_o = instr_valid_i && hazard;
   assign issue_o = instr_valid_i && !hazard;
   assign jump_o  = issue_o && cls.jump;
   assign halt_o  = issue_o && cls.halt;

   assign op_a_o   = cls.uses_a ? rf_da_i : '0;
   assign op_b_o   = cls.uses_b ? rf_db_i : '0;
   assign opcode_o = op;
   assign rd_o     = rd;
   assign rs1_o    = rs1;
   assign rs2_o    = rs2;
   assign imm_o    = imm;

   AST_JMP_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid_i && instr_i[15:12] == 4'd13) |-> jump_o) else $error("JMP blocked"); // R10
   AST_HLT_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid_i && instr_i[15:12] == 4'd15) |-> halt_o) else $error("HLT blocked"); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid_i |-> !(stall_o || issue_o || jump_o || halt_o)) else $error("output without valid"); // R5

endmodule

// File: tb/sbd_decoder_bench.sv
`timescale 1ns/1ps
module sbd_decoder_bench;

   localparam int DW   = 8;
   localparam int CW   = 2;
   localparam int MAXC = (1 << CW) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] instr = '0;
   logic        valid = 1'b0;
   logic        wb_en = 1'b0;
   logic [3:0]  wb_idx = '0;
   logic [3:0]  ra, rb, opc, rdf, s1, s2;
   logic [DW-1:0] da, db, opa, opb;
   logic [7:0]  imm;
   logic        issue, stall, jump, halt;

   logic [DW-1:0] rf [16];
   int cnt [16];
   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   assign da = rf[ra];
   assign db = rf[rb];

   sbd_decoder #(.DATA_W(DW), .CNT_W(CW)) u_sbd_decoder (
      .clk(clk), .rst_n(rst_n), .instr_i(instr), .instr_valid_i(valid),
      .wb_en_i(wb_en), .wb_idx_i(wb_idx), .rf_ra_o(ra), .rf_rb_o(rb),
      .rf_da_i(da), .rf_db_i(db), .opcode_o(opc), .rd_o(rdf), .rs1_o(s1),
      .rs2_o(s2), .imm_o(imm), .op_a_o(opa), .op_b_o(opb), .issue_o(issue),
      .stall_o(stall), .jump_o(jump), .halt_o(halt)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic classify(input int op, output bit ua, output bit ub, output bit ard,
                           output bit brd, output bit wr, output bit jp, output bit hl);
      ua  = (op <= 9) || op == 11 || op == 12 || op == 14;
      ub  = (op <= 2) || (op >= 4 && op <= 6) || op == 12;
      ard = (op == 3) || (op == 14);
      brd = (op == 12);
      wr  = (op <= 11);
      jp  = (op == 13) || (op == 14);
      hl  = (op == 15);
   endtask

   // Drive one cycle, check all outputs, then advance the model.
   task automatic step(input logic [15:0] ins, input bit v, input bit we, input logic [3:0] wi);
      bit ua, ub, ard, brd, wr, jp, hl, hz, e_iss;
      int op, d, a, b, ea, eb, eimm;
      @(negedge clk);
      instr = ins; valid = v; wb_en = we; wb_idx = wi;
      #1;
      op = ins[15:12]; d = ins[11:8];
      classify(op, ua, ub, ard, brd, wr, jp, hl);
      a = ard ? d : ins[7:4];
      b = brd ? d : ins[3:0];
      hz = (ua && cnt[a] != 0) || (ub && cnt[b] != 0) || (wr && cnt[d] == MAXC);
      e_iss = v && !hz;
      chk(opc == ins[15:12] && rdf == ins[11:8] && s1 == ins[7:4] && s2 == ins[3:0],
          "R1", {opc, rdf, s1, s2}, ins);
      eimm = (op == 13) ? ins[11:4] : ins[7:0];
      chk(imm == eimm, "R3", imm, eimm);
      ea = ua ? rf[a] : 0;
      eb = ub ? rf[b] : 0;
      chk(opa == ea && opb == eb, "R4", {opa, opb}, {ea[7:0], eb[7:0]});
      chk(stall == (v && hz) && issue == e_iss, "R5", {stall, issue}, {v && hz, e_iss});
      chk(jump == (e_iss && jp) && halt == (e_iss && hl), "R10", {jump, halt},
          {e_iss && jp, e_iss && hl});
      for (int r = 0; r < 16; r++) begin
         bit inc, dec;
         inc = e_iss && wr && d == r;
         dec = we && wi == r && cnt[r] > 0;
         if (inc && !dec) cnt[r]++;
         else if (dec && !inc) cnt[r]--;
      end
   endtask

   function automatic logic [15:0] mk(input int op, input int d, input int a, input int b);
      return {op[3:0], d[3:0], a[3:0], b[3:0]};
   endfunction

   // Probe with BEQZ on register r (reads rd, reserves nothing).
   task automatic probe(input int r, input bit exp_stall, input string req);
      step(mk(14, r, 0, 0), 1'b1, 1'b0, 4'd0);
      chk(stall == exp_stall, req, stall, exp_stall);
   endtask

   initial begin
      void'($urandom(32'h5BD0_0042));
      for (int r = 0; r < 16; r++) begin rf[r] = DW'($urandom); cnt[r] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11: nothing busy after reset
      for (int r = 0; r < 16; r++) probe(r, 1'b0, "R11");

      // R6: LI reserves rd; ST reserves nothing
      step(mk(10, 5, 4'hA, 4'h5), 1'b1, 1'b0, 4'd0);
      probe(5, 1'b1, "R6");
      step(mk(12, 2, 0, 0), 1'b1, 1'b0, 4'd0);
      probe(2, 1'b0, "R6");
      // R2: INC, ST and NOT with busy r5
      step(mk(3, 5, 0, 0), 1'b1, 1'b0, 4'd0);
      chk(stall == 1'b1, "R2", stall, 1);
      step(mk(12, 5, 1, 1), 1'b1, 1'b0, 4'd0);
      chk(stall == 1'b1, "R2", stall, 1);
      step(mk(7, 1, 5, 0), 1'b1, 1'b0, 4'd0);
      chk(stall == 1'b1, "R2", stall, 1);
      step(mk(7, 1, 0, 5), 1'b1, 1'b0, 4'd0);
      chk(stall == 1'b0, "R2", stall, 0);
      step(16'h0, 1'b0, 1'b1, 4'd1);

      // R8: issue and release on r5 together leave count 1
      step(mk(10, 5, 0, 0), 1'b1, 1'b1, 4'd5);
      probe(5, 1'b1, "R8");
      step(16'h0, 1'b0, 1'b1, 4'd5);
      probe(5, 1'b0, "R8");

      // R9: release on empty r7 ignored
      step(16'h0, 1'b0, 1'b1, 4'd7);
      step(mk(10, 7, 0, 0), 1'b1, 1'b0, 4'd0);
      chk(issue == 1'b1, "R9", issue, 1);
      step(16'h0, 1'b0, 1'b1, 4'd7);
      probe(7, 1'b0, "R9");

      // R7: fill r9 to its maximum
      for (int k = 0; k < MAXC; k++) step(mk(10, 9, 0, 0), 1'b1, 1'b0, 4'd0);
      step(mk(10, 9, 0, 0), 1'b1, 1'b0, 4'd0);
      chk(stall == 1'b1, "R7", stall, 1);
      step(mk(13, 0, 4'hB, 4'hA), 1'b1, 1'b0, 4'd0);
      chk(jump == 1'b1 && imm == 8'h0B, "R10", {jump, imm}, {1'b1, 8'h0B});
      for (int k = 0; k < MAXC; k++) step(16'h0, 1'b0, 1'b1, 4'd9);
      probe(9, 1'b0, "R7");

      // Random mix
      for (int i = 0; i < 4000; i++) begin
         if (($urandom % 16) == 0) rf[$urandom % 16] = DW'($urandom);
         step(16'($urandom), ($urandom % 5) != 0, ($urandom % 2) == 0, 4'($urandom));
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule